// File: doc/BRIEF.md
# Serial CRC-32 Frame Trailer Transmitter

This block takes the payload of one frame as a stream of bytes and turns it into a stream of 2-bit symbols for a downstream pulse-position modulator. The modulator consumes one symbol per strobe. Bits leave in least-significant-first order. While the bytes pass through, the block keeps a running CRC-32. When the byte marked as last has been fully shifted out, the block sends the inverted CRC as a 32-bit trailer, with no gap. It then raises a one-cycle completion pulse, which tells the surrounding logic that the closing flag may be sent.

The input is a valid/ready stream. A byte is taken on any rising clock edge where `s_valid` and `s_ready` are both high. `s_ready` is asserted only when the block can accept a byte in that cycle: either the shifter is empty, or its last symbol is being consumed by a strobe in the same cycle. In the second case consecutive bytes follow each other without a bubble. Back-pressure lasts from the acceptance of a last byte until the trailer has been consumed. The producer must hold its byte while `s_ready` is low. The symbol side has no back-pressure of its own: `tx_valid` says a symbol is present, and `sym_stb` consumes it.

Top module: `crc_dibit_tx`

## Requirements
- R1: While `rst_n` is low, `tx_valid` and `crc_done` are 0 and `s_ready` is 1.
- R2: An accepted byte is emitted as four symbols, bits 1:0 first and bits 7:6 last. In each symbol, `tx_sym[0]` is the earlier bit on the line.
- R3: Outside the trailer, `s_ready` is high exactly when the shifter is empty, or when it holds one symbol and `sym_stb` is high in the same cycle. The next byte's first symbol then appears in the cycle after that edge.
- R4: `tx_valid` and `tx_sym` hold steady until `sym_stb`. Each strobe consumes exactly one symbol. A strobe while `tx_valid` is low has no effect.
- R5: The CRC is reflected, with polynomial 0xEDB88320, preset to all ones at the start of every frame, and covers each payload byte LSB first. The payload "123456789" yields the trailer word 0xCBF43926. A single 0x00 byte yields 0xD202EF8D.
- R6: The trailer is the bitwise inverse of the CRC, sent as 16 symbols starting at bit 0. This puts the least significant byte first and the low nibble of each byte first. Its first symbol follows the last payload symbol with no idle cycle.
- R7: From the cycle after a last byte is accepted until the cycle of `crc_done`, `s_ready` stays low.
- R8: `crc_done` is high for exactly one cycle: the cycle after the strobe that consumes the final trailer symbol.
- R9: A byte presented while `s_ready` is low is not captured. Only bytes taken on a handshake appear on `tx_sym`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| s_valid | input | 1 | Payload byte present |
| s_ready | output | 1 | Block takes the byte on this edge |
| s_data | input | 8 | Payload byte |
| s_last | input | 1 | Marks the final byte of the frame |
| sym_stb | input | 1 | Symbol strobe from the modulator |
| tx_valid | output | 1 | A symbol is present on `tx_sym` |
| tx_sym | output | 2 | Current symbol, bit 0 earlier on the line |
| crc_done | output | 1 | One-cycle pulse after the trailer has been consumed |

## Verification
The payload "123456789" is sent with a strobe on every cycle. Its trailer word is compared with the published check value, which separates a wrong polynomial, preset, inversion or byte order from a correct one. A single zero byte then covers the shortest frame, where the trailer starts right after the first byte. Frames of random length and content run under a strobe every third cycle and a random strobe. With gaps in `s_valid`, these patterns separate the bubble-free hand-over between bytes from the empty-shifter case. A mode that drives junk bytes whenever `s_ready` should be low shows whether the block captures data during back-pressure and during the trailer.

// File: rtl/crc_dibit_pkg.sv
package crc_dibit_pkg;
  typedef enum logic {
    PH_PAYLOAD = 1'b0,
    PH_TRAILER = 1'b1
  } tx_phase_e;
endpackage

// File: rtl/crc_byte_step.sv
module crc_byte_step #(
  parameter int          CRC_W  = 32,
  parameter int          DATA_W = 8,
  parameter logic [31:0] POLY   = 32'hEDB88320
) (
  input  logic [CRC_W-1:0]  crc_in,
  input  logic [DATA_W-1:0] data_in,
  output logic [CRC_W-1:0]  crc_out
);
  logic [CRC_W-1:0] acc;

  always_comb begin
    acc = crc_in;
    for (int i = 0; i < DATA_W; i++) begin
      if (acc[0] ^ data_in[i]) acc = (acc >> 1) ^ POLY[CRC_W-1:0];
      else                     acc = acc >> 1;
    end
    crc_out = acc;
  end
endmodule

// File: rtl/sym_shift_unit.sv
module sym_shift_unit #(
  parameter int REG_W = 32,
  parameter int SYM_W = 2,
  parameter int CNT_W = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [REG_W-1:0] load_val,
  input  logic [CNT_W-1:0] load_cnt,
  input  logic             shift,
  output logic [SYM_W-1:0] sym,
  output logic [CNT_W-1:0] left
);
  logic [REG_W-1:0] sh_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q <= '0;
      left <= '0;
    end else if (load) begin
      sh_q <= load_val;
      left <= load_cnt;
    end else if (shift && left != '0) begin
      sh_q <= sh_q >> SYM_W;
      left <= left - CNT_W'(1);
    end
  end

  assign sym = sh_q[SYM_W-1:0];
endmodule

// File: rtl/crc_dibit_tx.sv
module crc_dibit_tx #(
  parameter int          DATA_W = 8,
  parameter int          CRC_W  = 32,
  parameter int          SYM_W  = 2,
  parameter logic [31:0] POLY   = 32'hEDB88320
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              s_valid,
  output logic              s_ready,
  input  logic [DATA_W-1:0] s_data,
  input  logic              s_last,
  input  logic              sym_stb,
  output logic              tx_valid,
  output logic [SYM_W-1:0]  tx_sym,
  output logic              crc_done
);
  import crc_dibit_pkg::*;

  localparam int BYTE_SYMS = DATA_W / SYM_W;
  localparam int CRC_SYMS  = CRC_W / SYM_W;
  localparam int CNT_W     = $clog2(CRC_SYMS + 1);

  tx_phase_e        phase_q;
  logic             last_pend_q;
  logic [CRC_W-1:0] crc_q;
  logic [CRC_W-1:0] crc_next;
  logic [CNT_W-1:0] left;
  logic             take, final_sym, accept, start_trailer;
  logic             load;
  logic [CRC_W-1:0] load_val;
  logic [CNT_W-1:0] load_cnt;

  assign take          = sym_stb && (left != '0);
  assign final_sym     = take && (left == CNT_W'(1));
  assign s_ready       = (phase_q == PH_PAYLOAD) &&
                         ((left == '0) || (final_sym && !last_pend_q));
  assign accept        = s_valid && s_ready;
  assign start_trailer = (phase_q == PH_PAYLOAD) && final_sym && last_pend_q;

  assign load     = accept || start_trailer;
  assign load_val = accept ? {{(CRC_W-DATA_W){1'b0}}, s_data} : ~crc_q;
  assign load_cnt = accept ? CNT_W'(BYTE_SYMS) : CNT_W'(CRC_SYMS);

  crc_byte_step #(.CRC_W(CRC_W), .DATA_W(DATA_W), .POLY(POLY)) u_step (
    .crc_in  (crc_q),
    .data_in (s_data),
    .crc_out (crc_next)
  );

  sym_shift_unit #(.REG_W(CRC_W), .SYM_W(SYM_W), .CNT_W(CNT_W)) u_shift (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (load),
    .load_val (load_val),
    .load_cnt (load_cnt),
    .shift    (take),
    .sym      (tx_sym),
    .left     (left)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q     <= PH_PAYLOAD;
      last_pend_q <= 1'b0;
      crc_q       <= '1;
      crc_done    <= 1'b0;
    end else begin
      crc_done <= (phase_q == PH_TRAILER) && final_sym;
      if (accept) begin
        crc_q       <= crc_next;
        last_pend_q <= s_last;
      end else if (start_trailer) begin
        crc_q       <= '1;
        last_pend_q <= 1'b0;
      end
      if (start_trailer)                            phase_q <= PH_TRAILER;
      else if (phase_q == PH_TRAILER && final_sym)  phase_q <= PH_PAYLOAD;
    end
  end

  assign tx_valid = (left != '0);
endmodule

// File: rtl/crc_dibit_tx_chk.sv
module crc_dibit_tx_chk #(
  parameter int DATA_W = 8,
  parameter int SYM_W  = 2
) (
  input logic              clk,
  input logic              rst_n,
  input logic              s_valid,
  input logic              s_ready,
  input logic [DATA_W-1:0] s_data,
  input logic              s_last,
  input logic              sym_stb,
  input logic              tx_valid,
  input logic [SYM_W-1:0]  tx_sym,
  input logic              crc_done
);
  logic in_trl;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                           in_trl <= 1'b0;
    else if (s_valid && s_ready && s_last) in_trl <= 1'b1;
    else if (crc_done)                     in_trl <= 1'b0;
  end

  a_r4_hold: assert property (@(posedge clk) disable iff (!rst_n)
    tx_valid && !sym_stb |=> tx_valid && $stable(tx_sym));

  a_r3_ready_drain: assert property (@(posedge clk) disable iff (!rst_n)
    s_ready |-> (!tx_valid || sym_stb));

  a_r7_ready_low_after_last: assert property (@(posedge clk) disable iff (!rst_n)
    s_valid && s_ready && s_last |=> !s_ready);

  a_r7_ready_low_in_trailer: assert property (@(posedge clk) disable iff (!rst_n)
    in_trl && !crc_done |-> !s_ready);

  a_r6_trailer_gapless: assert property (@(posedge clk) disable iff (!rst_n)
    in_trl && !crc_done |-> tx_valid);

  a_r8_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    crc_done |=> !crc_done);

  a_r8_after_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    crc_done |-> $past(sym_stb && tx_valid));
endmodule

bind crc_dibit_tx crc_dibit_tx_chk #(.DATA_W(DATA_W), .SYM_W(SYM_W)) u_chk (.*);

// File: tb/crc_dibit_tx_tb.sv
`timescale 1ns/1ps
module crc_dibit_tx_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       s_valid = 1'b0;
  logic       s_ready;
  logic [7:0] s_data = '0;
  logic       s_last = 1'b0;
  logic       sym_stb = 1'b0;
  logic       tx_valid;
  logic [1:0] tx_sym;
  logic       crc_done;

  crc_dibit_tx u_dut (
    .clk(clk), .rst_n(rst_n), .s_valid(s_valid), .s_ready(s_ready),
    .s_data(s_data), .s_last(s_last), .sym_stb(sym_stb),
    .tx_valid(tx_valid), .tx_sym(tx_sym), .crc_done(crc_done)
  );

  always #2.5 clk = ~clk;

  int          checks = 0;
  int          fails  = 0;
  int          cyc    = 0;
  int unsigned q[$];
  int          trail_cnt = 0;
  bit          exp_done = 1'b0;
  bit          fin = 1'b0;
  logic [31:0] mcrc = '1;
  logic [31:0] tword = '0;
  logic [7:0]  fr[$];

  always @(posedge clk) begin
    cyc++;
    if (cyc == 150000) begin
      fails++; checks++;
      $display("FAIL watchdog: run hung (actual cycles %0d, expected fewer)", cyc);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  function automatic logic [31:0] crc_upd(input logic [31:0] c, input logic [7:0] d);
    logic [31:0] r = c;
    for (int i = 0; i < 8; i++) begin
      r = (r[0] ^ d[i]) ? ((r >> 1) ^ 32'hEDB88320) : (r >> 1);
    end
    return r;
  endfunction

  // One cycle: check outputs, drive inputs, check ready, advance the model.
  task automatic step(input bit stb, input bit has_byte, input logic [7:0] d,
                      input bit lst, input bit junk, output bit took);
    bit          er;
    int unsigned it;
    @(negedge clk);
    chk(tx_valid === (q.size() != 0), "R4", "tx_valid", 32'(tx_valid), 32'(q.size() != 0));
    if (q.size() != 0)
      chk(tx_sym === q[0][1:0], (q[0] & 4) != 0 ? "R6" : "R2", "tx_sym",
          32'(tx_sym), 32'(q[0][1:0]));
    chk(crc_done === exp_done, "R8", "crc_done", 32'(crc_done), 32'(exp_done));
    exp_done = 1'b0;
    er = (trail_cnt == 0) && (q.size() == 0 || (q.size() == 1 && stb));
    sym_stb = stb;
    if (junk && !er) begin
      s_valid = 1'b1; s_data = 8'($urandom); s_last = 1'($urandom);
    end else if (has_byte) begin
      s_valid = 1'b1; s_data = d; s_last = lst;
    end else begin
      s_valid = 1'b0; s_data = 8'($urandom); s_last = 1'b0;
    end
    #1;
    chk(s_ready === er, trail_cnt > 0 ? "R7" : "R3", "s_ready", 32'(s_ready), 32'(er));
    took = 1'b0;
    if (stb && q.size() != 0) begin
      it = q.pop_front();
      if ((it & 4) != 0) begin
        trail_cnt--;
        tword = {it[1:0], tword[31:2]};
        if ((it & 8) != 0) begin exp_done = 1'b1; fin = 1'b1; end
      end
    end
    if (s_valid && s_ready) begin
      if (!has_byte || (junk && !er)) begin
        chk(1'b0, "R9", "byte captured under back-pressure", 32'(s_data), 32'h0);
      end else begin
        took = 1'b1;
        for (int k = 0; k < 4; k++) q.push_back(int'((d >> (2*k)) & 8'h3));
        mcrc = crc_upd(mcrc, d);
        if (lst) begin
          for (int k = 0; k < 16; k++)
            q.push_back(int'(((~mcrc) >> (2*k)) & 32'h3) | 4 | (k == 15 ? 8 : 0));
          trail_cnt = 16;
          mcrc = '1;
        end
      end
    end
  endtask

  function automatic bit pick_stb(input int mode);
    if (mode == 0) return 1'b1;
    if (mode == 1) return (cyc % 3) == 0;
    return 1'($urandom);
  endfunction

  task automatic run_frame(input int smode, input bit gaps, input bit junk);
    int idx = 0;
    bit took;
    bit offer;
    fin = 1'b0;
    while (!fin) begin
      offer = (idx < fr.size()) && (!gaps || ($urandom % 3 != 0));
      step(pick_stb(smode), offer, offer ? fr[idx] : 8'h00,
           offer && (idx == fr.size() - 1), junk, took);
      if (took) idx++;
    end
  endtask

  initial begin
    bit took;
    repeat (3) begin
      @(negedge clk);
      sym_stb = 1'($urandom);
      #1;
      chk(tx_valid === 1'b0 && crc_done === 1'b0 && s_ready === 1'b1, "R1",
          "reset outputs", {29'h0, tx_valid, crc_done, s_ready}, 32'h1);
    end
    rst_n = 1'b1;

    // Known vector, strobe every cycle (R5, R2, R6).
    fr = {8'h31, 8'h32, 8'h33, 8'h34, 8'h35, 8'h36, 8'h37, 8'h38, 8'h39};
    run_frame(0, 1'b0, 1'b0);
    chk(tword == 32'hCBF43926, "R5", "trailer for 123456789", tword, 32'hCBF43926);

    // Shortest frame, one zero byte, sparse strobe, junk under back-pressure (R9).
    fr = {8'h00};
    run_frame(1, 1'b0, 1'b1);
    chk(tword == 32'hD202EF8D, "R5", "trailer for single zero byte", tword, 32'hD202EF8D);

    // Random frames across strobe and gap patterns.
    for (int f = 0; f < 24; f++) begin
      int len = 1 + ($urandom % 20);
      fr.delete();
      for (int b = 0; b < len; b++) fr.push_back(8'($urandom));
      run_frame(f % 3, (f % 2) == 1, (f % 4) >= 2);
    end

    // Idle: strobes with nothing queued must have no effect (R4).
    repeat (10) step(1'($urandom), 1'b0, 8'h00, 1'b0, 1'b0, took);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule